// File: doc/BRIEF.md
# I2C Lockable Byte Memory Slave

This block is an I2C slave that gives a host access to an 8192-byte memory. The memory is a register array inside the block. The bus clock and data lines are oversampled with the system clock, so the block runs entirely in one clock domain. The slave decodes a device byte that carries two strap-select bits, which lets up to four of these blocks share one bus. It then accepts a two-byte word address. After that it performs byte writes, page writes that wrap within a 64-byte page, and sequential reads that run across the whole array.

A small control register chooses a locked region at the top of the address space. The region can be empty, 64, 128, 256 or 512 bytes, a quarter of the array, half of it, or all of it. A data byte aimed at a locked address is acknowledged but is not stored. The control register has a freeze-enable bit. When the write-protect input is high and that bit is set, the control register cannot be changed from the bus.

The block has a single open-drain style output: it only ever pulls the data line low, and the pad logic outside the block performs the actual pull-down. The bus is meant to run at up to 400 kHz. The oversampling needs each SCL phase to last at least a few system clocks.

Top module: `i2c_lockmem`

## Requirements
- R1: The device byte is laid out as bits [7:4] = kind, bit 3 = 0, bits [2:1] = `sel_i`, and bit 0 = direction (1 = read). Kind 4'b1010 selects the memory and kind 4'b1011 selects the control register. A device byte that matches neither kind, has bit 3 set, or has select bits different from `sel_i` is NACKed. The slave then acknowledges nothing until the next START.
- R2: The slave changes `sda_pull_o` only after a falling SCL edge, or to release the line on START/STOP. It never pulls the line low while the host is sending a data bit.
- R3: A memory write sends two address bytes. The high byte supplies address bits [12:8], and its upper three bits are ignored. The low byte supplies bits [7:0]. Each following data byte to an unlocked address is stored and acknowledged.
- R4: Within one write transfer, only the low six address bits advance after each data byte, wrapping from 0x3F to 0x00. The upper seven bits stay fixed.
- R5: A read returns the byte at the current address and then increments the 13-bit address. The address rolls over from 0x1FFF to 0x0000. A master NACK ends the transfer.
- R6: A read that follows a write-addressed transfer, either through a repeated START or after a STOP, starts at the address left by that transfer.
- R7: Control bits [2:0] select the locked region at the top of the array: 0 none, 1 top 64 bytes, 2 top 128, 3 top 256, 4 top 512, 5 top quarter, 6 top half, 7 all. A data byte to a locked address is ACKed but not stored, and the address still advances.
- R8: A control write is the control device byte followed by one data byte. A control read returns {freeze, 4'b0000, zone}, where bit 7 is the freeze enable.
- R9: While `wp_i` is high and the freeze bit is set, a control write is ACKed but leaves the register unchanged.
- R10: After reset the control register is 0, the slave is idle and `sda_pull_o` is low.
- R11: A STOP returns the slave to idle. A START at any point restarts device-byte decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sel_i | input | 2 | Strap-select bits compared with device byte bits [2:1] |
| wp_i | input | 1 | Write-protect input, effective when the freeze bit is set |
| sda_pull_o | output | 1 | High to pull the data line low |

## Verification
On every cycle, the assertions check the following: the data-line pull moves only on SCL falls or bus conditions, the line is released when idle, and a mismatched device byte gets no acknowledge. They also check that the pointer steps as a page-wrapped value on writes and as a full-width rolling value on reads, that a frozen control register holds its value, and that the lock decode is empty for zone 0 and total for zone 7. Only the bench scenarios can show what actually lands in the array. That covers the byte placed at each lock boundary under every zone code, the page-wrapped data, reads across the top of the array, control read-back with its reserved zeros, and current-address reads after a STOP.

// File: rtl/i2cmem_pkg.sv
// Shared types for the I2C lockable memory slave.
// Assumes: byte-wide bus transfers; phases are tracked per byte.
package i2cmem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEVICE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_MEM_WR,
        PH_MEM_RD,
        PH_CTL_WR,
        PH_CTL_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       freeze_en;
        logic [2:0] zone;
    } ctl_s;

    // True for phases in which the host sends the byte
    function automatic logic is_rx(input phase_e p);
        return (p == PH_DEVICE) || (p == PH_ADDR_HI) || (p == PH_ADDR_LO) ||
               (p == PH_MEM_WR) || (p == PH_CTL_WR);
    endfunction

    // True for phases in which the slave sends the byte
    function automatic logic is_tx(input phase_e p);
        return (p == PH_MEM_RD) || (p == PH_CTL_RD);
    endfunction

endpackage

// File: rtl/i2cmem_line_sync.sv
// Brings SCL and SDA into the clock domain and flags edges and bus conditions.
// Assumes: each SCL phase lasts several clk periods; event flags are one cycle wide.
module i2cmem_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_bit
);

    localparam int LAST = SYNC_STAGES;
    localparam int CUR  = SYNC_STAGES - 1;

    logic [LAST:0] scl_sh;
    logic [LAST:0] sda_sh;

    // Shift both lines through the synchronizer chain; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[LAST-1:0], scl_i};
            sda_sh <= {sda_sh[LAST-1:0], sda_i};
        end
    end

    assign scl_rise  = scl_sh[CUR] & ~scl_sh[LAST];
    assign scl_fall  = ~scl_sh[CUR] & scl_sh[LAST];
    assign start_evt = scl_sh[CUR] & scl_sh[LAST] & sda_sh[LAST] & ~sda_sh[CUR];
    assign stop_evt  = scl_sh[CUR] & scl_sh[LAST] & ~sda_sh[LAST] & sda_sh[CUR];
    assign sda_bit   = sda_sh[CUR];

endmodule

// File: rtl/i2cmem_lock_map.sv
// Decides whether an address lies in the locked region chosen by the zone code.
// Assumes: the region always ends at the top address; code 0 locks nothing.
module i2cmem_lock_map #(
    parameter int ADDR_W     = 13,
    parameter int SMALL_LOG2 = 6
) (
    input  logic [2:0]        zone_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);

    localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] ONE  = {{ADDR_W{1'b0}}, 1'b1};

    logic [ADDR_W:0] span;
    logic [ADDR_W:0] base;

    // Size of the locked region for each zone code
    always_comb begin
        unique case (zone_i)
            3'd1:    span = ONE << SMALL_LOG2;
            3'd2:    span = ONE << (SMALL_LOG2 + 1);
            3'd3:    span = ONE << (SMALL_LOG2 + 2);
            3'd4:    span = ONE << (SMALL_LOG2 + 3);
            3'd5:    span = FULL >> 2;
            3'd6:    span = FULL >> 1;
            3'd7:    span = FULL;
            default: span = '0;
        endcase
    end

    assign base     = FULL - span;
    assign locked_o = (span != '0) && ({1'b0, addr_i} >= base);

endmodule

// File: rtl/i2cmem_store.sv
// Byte array with one write port and an asynchronous read port.
// Assumes: contents are not reset; write and read share the pointer outside.
module i2cmem_store #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [0:DEPTH-1];

    // Store one byte when enabled
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/i2c_lockmem.sv
// I2C slave front end for a lockable byte memory plus a small control register.
// Decodes the device byte, a two-byte address, page-wrapped writes and
// rolling sequential reads; blocks writes to the locked top region.
// Assumes: SCL phases last several clk periods; the pad turns sda_pull_o into
// an open-drain low drive; sda_i is the resolved wire level.
module i2c_lockmem
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W      = 13,
    parameter int         PAGE_W      = 6,
    parameter int         SMALL_LOG2  = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] MEM_KIND    = 4'b1010,
    parameter logic [3:0] CTL_KIND    = 4'b1011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] sel_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);

    localparam int HI_W = ADDR_W - BYTE_W;

    logic scl_rise, scl_fall, start_evt, stop_evt, sda_bit;

    phase_e              phase, nxt_ph, byte_next;
    logic [3:0]          bit_cnt;
    logic                in_ack, mack;
    logic [BYTE_W-1:0]   rx_sr, tx_sr;
    logic [ADDR_W-1:0]   ptr;
    logic [HI_W-1:0]     hi_q;
    ctl_s                ctl_q;
    logic                sda_pull;

    logic                rx_ph, tx_ph;
    logic                rx_done, ack_end, tx_cont;
    logic                rd_step, ctl_load, wr_step;
    logic                mem_we, ctl_we, zone_hit;
    logic                hit_mem, hit_ctl, byte_ack;
    logic [BYTE_W-1:0]   rdata, ctl_byte, load_byte;

    i2cmem_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_bit   (sda_bit)
    );

    i2cmem_lock_map #(.ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2)) u_lock (
        .zone_i   (ctl_q.zone),
        .addr_i   (ptr),
        .locked_o (zone_hit)
    );

    i2cmem_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (ptr),
        .wdata_i (rx_sr),
        .raddr_i (ptr),
        .rdata_o (rdata)
    );

    assign rx_ph    = is_rx(phase);
    assign tx_ph    = is_tx(phase);
    assign rx_done  = rx_ph && scl_fall && (bit_cnt == 4'd8) && !in_ack;
    assign ack_end  = rx_ph && scl_fall && in_ack;
    assign tx_cont  = tx_ph && scl_fall && (bit_cnt == 4'd9) && mack;
    assign rd_step  = (ack_end && nxt_ph == PH_MEM_RD) || (tx_cont && phase == PH_MEM_RD);
    assign ctl_load = (ack_end && nxt_ph == PH_CTL_RD) || (tx_cont && phase == PH_CTL_RD);
    assign wr_step  = rx_done && (phase == PH_MEM_WR);
    assign mem_we   = wr_step && !zone_hit;
    assign ctl_we   = rx_done && (phase == PH_CTL_WR) && !(wp_i && ctl_q.freeze_en);
    assign ctl_byte = {ctl_q.freeze_en, 4'b0000, ctl_q.zone};
    assign load_byte = rd_step ? rdata : ctl_byte;
    assign sda_pull_o = sda_pull;

    // Decode the completed byte: acknowledge decision and following phase
    always_comb begin
        hit_mem = (rx_sr[7:4] == MEM_KIND) && !rx_sr[3] && (rx_sr[2:1] == sel_i);
        hit_ctl = (rx_sr[7:4] == CTL_KIND) && !rx_sr[3] && (rx_sr[2:1] == sel_i);
        byte_ack  = 1'b1;
        byte_next = PH_SKIP;
        unique case (phase)
            PH_DEVICE: begin
                byte_ack = hit_mem || hit_ctl;
                if (hit_mem)      byte_next = rx_sr[0] ? PH_MEM_RD : PH_ADDR_HI;
                else if (hit_ctl) byte_next = rx_sr[0] ? PH_CTL_RD : PH_CTL_WR;
                else              byte_next = PH_SKIP;
            end
            PH_ADDR_HI: byte_next = PH_ADDR_LO;
            PH_ADDR_LO: byte_next = PH_MEM_WR;
            PH_MEM_WR:  byte_next = PH_MEM_WR;
            PH_CTL_WR:  byte_next = PH_CTL_WR;
            default: begin
                byte_ack  = 1'b0;
                byte_next = PH_SKIP;
            end
        endcase
    end

    // Track the byte phase, bit position and master acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            nxt_ph  <= PH_IDLE;
            bit_cnt <= 4'd0;
            in_ack  <= 1'b0;
            mack    <= 1'b0;
            rx_sr   <= '0;
        end else if (start_evt) begin
            phase   <= PH_DEVICE;
            bit_cnt <= 4'd0;
            in_ack  <= 1'b0;
        end else if (stop_evt) begin
            phase   <= PH_IDLE;
            bit_cnt <= 4'd0;
            in_ack  <= 1'b0;
        end else if (rx_ph) begin
            if (scl_rise && bit_cnt < 4'd8) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], sda_bit};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (rx_done) begin
                in_ack <= 1'b1;
                nxt_ph <= byte_next;
            end else if (ack_end) begin
                in_ack  <= 1'b0;
                bit_cnt <= 4'd0;
                phase   <= nxt_ph;
            end
        end else if (tx_ph) begin
            if (scl_rise && bit_cnt < 4'd8) begin
                bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_rise && bit_cnt == 4'd8) begin
                mack    <= !sda_bit;
                bit_cnt <= 4'd9;
            end else if (scl_fall && bit_cnt == 4'd9) begin
                if (mack) bit_cnt <= 4'd0;
                else      phase   <= PH_SKIP;
            end
        end
    end

    // Drive the data-line pull for acknowledges and outgoing bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            tx_sr    <= '0;
        end else if (start_evt || stop_evt) begin
            sda_pull <= 1'b0;
        end else if (rx_done) begin
            sda_pull <= byte_ack;
        end else if (ack_end) begin
            if (rd_step || ctl_load) begin
                tx_sr    <= load_byte;
                sda_pull <= ~load_byte[BYTE_W-1];
            end else begin
                sda_pull <= 1'b0;
            end
        end else if (tx_ph && scl_fall) begin
            if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
                tx_sr    <= tx_sr << 1;
                sda_pull <= ~tx_sr[BYTE_W-2];
            end else if (tx_cont) begin
                tx_sr    <= load_byte;
                sda_pull <= ~load_byte[BYTE_W-1];
            end else begin
                sda_pull <= 1'b0;
            end
        end
    end

    // Maintain the word pointer: load, page-wrapped write step, full read step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            hi_q <= '0;
        end else if (rx_done && phase == PH_ADDR_HI) begin
            hi_q <= rx_sr[HI_W-1:0];
        end else if (rx_done && phase == PH_ADDR_LO) begin
            ptr <= {hi_q, rx_sr};
        end else if (wr_step) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
        end else if (rd_step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Hold the control register; writes pass only when not frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= {rx_sr[BYTE_W-1], rx_sr[2:0]};
        end
    end

    // R1: a mismatched device byte gets no acknowledge in its slot
    a_r1_nack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && phase == PH_DEVICE && !hit_mem && !hit_ctl) |=> !sda_pull_o);

    // R2: the pull moves only on SCL falls or bus conditions
    a_r2_pull_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_pull_o));

    // R10/R11: an idle slave never holds the line
    a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull_o);

    // R4: a written byte steps only the in-page bits
    a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_step |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
                    (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));

    // R5: a loaded read byte steps the full pointer with rollover
    a_r5_read_roll: assert property (@(posedge clk) disable iff (!rst_n)
        rd_step |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R9: a frozen control register holds its value
    a_r9_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_i && ctl_q.freeze_en) |=> $stable(ctl_q));

    // R7: zone 0 locks nothing, zone 7 locks everything
    a_r7_zone_none: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.zone == 3'd0) |-> !zone_hit);
    a_r7_zone_all: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.zone == 3'd7) |-> zone_hit);

endmodule

// File: tb/i2c_lockmem_test.sv
// Directed bench: a bit-level bus master, one task per scenario.
module i2c_lockmem_test;

    localparam int Q = 6;
    localparam logic [7:0] DEVW = 8'hA4;
    localparam logic [7:0] DEVR = 8'hA5;
    localparam logic [7:0] CTLW = 8'hB4;
    localparam logic [7:0] CTLR = 8'hB5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [1:0] sel = 2'b10;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit all_ack = 1'b1;
    bit data_pull_seen = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_lockmem uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sel_i      (sel),
        .wp_i       (wp),
        .sda_pull_o (sda_pull)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b0; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b1; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq;
            scl_m = 1'b1; wq;
            if (sda_pull) data_pull_seen = 1'b1;
            wq;
            scl_m = 1'b0; wq;
        end
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        ack = !sda_line;
        wq;
        scl_m = 1'b0; wq;
        if (!ack) all_ack = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq;
            scl_m = 1'b1; wq;
            b = {b[6:0], sda_line};
            wq;
            scl_m = 1'b0;
        end
        wq;
        sda_m = give_ack ? 1'b0 : 1'b1; wq;
        scl_m = 1'b1; wq; wq;
        scl_m = 1'b0; wq;
        sda_m = 1'b1;
    endtask

    task automatic mem_wr(input logic [15:0] a, input int n, input logic [31:0] d);
        logic ack;
        bus_start;
        send_byte(DEVW, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        for (int i = n - 1; i >= 0; i--) send_byte(d[i*8 +: 8], ack);
        bus_stop;
    endtask

    task automatic mem_rd(input logic [15:0] a, input int n, output logic [31:0] d);
        logic ack;
        logic [7:0] b;
        d = '0;
        bus_start;
        send_byte(DEVW, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        bus_start;
        send_byte(DEVR, ack);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            d = {d[23:0], b};
        end
        bus_stop;
    endtask

    task automatic cur_rd(output logic [7:0] b);
        logic ack;
        bus_start;
        send_byte(DEVR, ack);
        recv_byte(1'b0, b);
        bus_stop;
    endtask

    task automatic ctl_wr(input logic [7:0] v);
        logic ack;
        bus_start;
        send_byte(CTLW, ack);
        send_byte(v, ack);
        bus_stop;
    endtask

    task automatic ctl_rd(output logic [7:0] v);
        logic ack;
        bus_start;
        send_byte(CTLR, ack);
        recv_byte(1'b0, v);
        bus_stop;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk(sda_pull == 1'b0, "R10 line released after reset", 32'(sda_pull), 32'h0);
        ctl_rd(v);
        chk(v == 8'h00, "R10 control register cleared", 32'(v), 32'h0);
    endtask

    task automatic t_address;
        logic ack;
        bus_start;
        send_byte(8'hA2, ack);
        chk(!ack, "R1 wrong select bits NACKed", 32'(ack), 32'h0);
        send_byte(8'h00, ack);
        chk(!ack, "R1 bytes after mismatch ignored", 32'(ack), 32'h0);
        bus_stop;
        bus_start;
        send_byte(8'hAC, ack);
        chk(!ack, "R1 fixed bit 3 set NACKed", 32'(ack), 32'h0);
        bus_stop;
        bus_start;
        send_byte(8'h94, ack);
        chk(!ack, "R1 unknown kind NACKed", 32'(ack), 32'h0);
        bus_stop;
        bus_start;
        send_byte(DEVW, ack);
        chk(ack, "R1 matching device byte ACKed", 32'(ack), 32'h1);
        bus_stop;
    endtask

    task automatic t_byte_write;
        logic [31:0] d;
        all_ack = 1'b1;
        mem_wr(16'hE123, 1, 32'h5A);
        chk(all_ack, "R3 byte write acknowledged", 32'(all_ack), 32'h1);
        mem_rd(16'h0123, 1, d);
        chk(d[7:0] == 8'h5A, "R3 R6 high address bits masked, byte stored", d, 32'h5A);
    endtask

    task automatic t_stop_then_read;
        logic ack;
        logic [7:0] b;
        bus_start;
        send_byte(DEVW, ack);
        send_byte(8'h01, ack);
        send_byte(8'h23, ack);
        bus_stop;
        chk(sda_pull == 1'b0, "R11 line released after stop", 32'(sda_pull), 32'h0);
        cur_rd(b);
        chk(b == 8'h5A, "R11 R6 read after stop uses loaded address", 32'(b), 32'h5A);
        bus_start;
        send_byte(DEVW, ack);
        bus_start;
        send_byte(DEVR, ack);
        chk(ack, "R11 start mid transfer restarts decode", 32'(ack), 32'h1);
        recv_byte(1'b0, b);
        bus_stop;
    endtask

    task automatic t_page_wrap;
        logic [31:0] d;
        mem_wr(16'h0080, 1, 32'hC3);
        mem_wr(16'h007E, 4, 32'h11223344);
        mem_rd(16'h007E, 2, d);
        chk(d[15:0] == 16'h1122, "R4 bytes before page end", d, 32'h1122);
        mem_rd(16'h0040, 2, d);
        chk(d[15:0] == 16'h3344, "R4 bytes wrapped to page start", d, 32'h3344);
        mem_rd(16'h0080, 1, d);
        chk(d[7:0] == 8'hC3, "R4 next page untouched", d, 32'hC3);
    endtask

    task automatic t_seq_roll;
        logic [31:0] d;
        logic [7:0] b;
        mem_wr(16'h1FFE, 2, 32'hA1A2);
        mem_wr(16'h0000, 2, 32'hB1B2);
        mem_rd(16'h1FFE, 3, d);
        chk(d[23:0] == 24'hA1A2B1, "R5 sequential read rolls over", d, 32'hA1A2B1);
        cur_rd(b);
        chk(b == 8'hB2, "R6 current read continues after rollover", 32'(b), 32'hB2);
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        ctl_wr(8'hFF);
        ctl_rd(v);
        chk(v == 8'h87, "R8 reserved bits read zero", 32'(v), 32'h87);
        ctl_wr(8'h01);
        ctl_rd(v);
        chk(v == 8'h01, "R9 write allowed with protect pin low", 32'(v), 32'h01);
        ctl_wr(8'h80);
        wp = 1'b1;
        all_ack = 1'b1;
        ctl_wr(8'h05);
        chk(all_ack, "R9 frozen write still ACKed", 32'(all_ack), 32'h1);
        ctl_rd(v);
        chk(v == 8'h80, "R9 frozen register unchanged", 32'(v), 32'h80);
        wp = 1'b0;
        ctl_wr(8'h00);
        ctl_rd(v);
        chk(v == 8'h00, "R8 register writable again", 32'(v), 32'h00);
    endtask

    task automatic t_lock;
        logic [31:0] d;
        logic [7:0] b;
        for (int z = 1; z <= 7; z++) begin
            int span;
            int base;
            logic [7:0] p1;
            logic [7:0] p2;
            span = (z <= 4) ? (64 << (z - 1)) : (z == 5) ? 2048 : (z == 6) ? 4096 : 8192;
            base = 8192 - span;
            p1 = 8'h10 + 8'(z);
            p2 = 8'h80 + 8'(z);
            ctl_wr(8'h00);
            if (base > 0) mem_wr(16'(base - 1), 1, 32'(p1));
            mem_wr(16'(base), 1, 32'(p1));
            if (z == 1) mem_wr(16'(base + 1), 1, 32'h3C);
            ctl_wr(8'(z));
            all_ack = 1'b1;
            if (base > 0) mem_wr(16'(base - 1), 1, 32'(p2));
            mem_wr(16'(base), 1, 32'(p2));
            chk(all_ack, $sformatf("R7 zone %0d locked byte ACKed", z), 32'(all_ack), 32'h1);
            if (z == 1) begin
                cur_rd(b);
                chk(b == 8'h3C, "R7 address advances past locked byte", 32'(b), 32'h3C);
            end
            if (base > 0) begin
                mem_rd(16'(base - 1), 1, d);
                chk(d[7:0] == p2, $sformatf("R7 zone %0d byte below region stored", z), d, 32'(p2));
            end
            mem_rd(16'(base), 1, d);
            chk(d[7:0] == p1, $sformatf("R7 zone %0d first locked byte kept", z), d, 32'(p1));
        end
        ctl_wr(8'h00);
    endtask

    task automatic t_line_discipline;
        chk(!data_pull_seen, "R2 no pull while host sends data", 32'(data_pull_seen), 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_address;
        t_byte_write;
        t_stop_then_read;
        t_page_wrap;
        t_seq_roll;
        t_ctrl;
        t_lock;
        t_line_discipline;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule